// File: doc/BRIEF.md
# Streaming patch moment accumulator

This block takes a raster stream of pixels, one per clock, and for every position where a square patch of side 2R+1 fits inside the image it produces the two first-order intensity moments of that patch about its centre. The horizontal moment weights each pixel by its column offset from the centre. The vertical moment weights each pixel by its row offset. Both moments are returned in sign-magnitude form with a fixed output width. A downstream orientation stage would consume them.

No frame is stored. Each image column keeps a running pixel sum and a running row-weighted sum over the last 2R+1 rows. The pixel that leaves a column comes from a delay of 2R+1 lines. Along the line, two moving sums of those column values are kept. Each new column updates them with a constant number of additions. The weight shift caused by the window sliding one place is folded into the same update. Every multiplication is by the constant R or R+1 and is built from shifts and adds.

Top module: `patch_moment_acc`

## Requirements
- R1: For a valid output whose newest pixel is at column x, row y, the window centre is (cx, cy) = (x-R, y-R). The horizontal moment equals the sum of (c-cx)·p over every pixel p of the patch, where c is the pixel's column. Columns increase to the right.
- R2: The vertical moment equals the sum of (r-cy)·p over the patch, where r is the pixel's row. Rows increase with each later line, so later lines carry positive weights.
- R3: A pixel sampled on a rising edge that completes a window produces `out_valid` and its moments after the fifth rising edge, counting the sampling edge as the first.
- R4: Each moment is output as a 12-bit magnitude plus a sign bit. The sign bit is 1 exactly when the moment is negative. The magnitude is |moment| shifted right by S, dropping the low bits. S is the bit count of the largest possible magnitude 255·(2R+1)·R(R+1)/2 minus 12. With the defaults this is 17-12 = 5.
- R5: `out_valid` rises only for pixels with column index ≥ 2R and row index ≥ 2R. Both indices count from 0. The column index counts from the last line start. The row index counts line starts since reset.
- R6: A cycle with `in_valid` low changes neither the window state nor the output sequence.
- R7: A pixel with `in_sol` high starts a new line at column 0. No pixel of an earlier line enters a window of the new line. Every line carries the same number of pixels, at most IMG_W.
- R8: After reset, `out_valid` is 0 and both magnitudes and signs are 0. Valid pixels arriving before the first line start are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also marks the frame boundary |
| in_valid | input | 1 | Pixel present this cycle |
| in_sol | input | 1 | First pixel of a line (qualified by in_valid) |
| in_pix | input | PIX_W | Pixel intensity |
| out_valid | output | 1 | Moments below belong to a complete window |
| out_m10_mag | output | OUT_W | Truncated magnitude of the horizontal moment |
| out_m10_neg | output | 1 | Horizontal moment is negative |
| out_m01_mag | output | OUT_W | Truncated magnitude of the vertical moment |
| out_m01_neg | output | 1 | Vertical moment is negative |

## Verification
The first windows of each line are targeted. A design that failed to clear the along-line sums at a line start would leak a bright tail from the previous line into them and report a wrong, often negative, horizontal moment. The first 2R+1 rows are targeted as well. A design that did not suppress the departing pixel or the stale column sum there would add garbage from uninitialised storage. Input bubbles, including ones placed just before a line start, would expose a design that advances its window on idle cycles, as a shifted or late result. A half-bright image drives the horizontal moment to its extreme negative value, which checks the sign bit, the truncation shift and the absence of overflow. Results arriving one cycle early or late are reported against the exact expected edge.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
  localparam int ACC_BITS = 32;
  typedef logic signed [ACC_BITS-1:0] acc_t;

  // Product by a small constant built from shifted copies only.
  function automatic acc_t mul_k(input acc_t v, input int unsigned k);
    acc_t s;
    s = '0;
    for (int i = 0; i < 16; i++)
      if (k[i]) s = s + (v <<< i);
    return s;
  endfunction

  // One slide of a weighted window sum whose weights run -r..+r with the
  // newest element at +r: drop the leaver, shift all weights down by one,
  // add the newcomer. s_old is the plain sum before the slide.
  function automatic acc_t wsum_step(input acc_t w_old, input acc_t s_old,
                                     input acc_t leave, input acc_t enter,
                                     input int unsigned r);
    return w_old + mul_k(leave, r + 1) - s_old + mul_k(enter, r);
  endfunction

  function automatic acc_t abs_shift(input acc_t v, input int unsigned sh);
    acc_t a;
    a = (v < 0) ? -v : v;
    return a >>> sh;
  endfunction
endpackage

// File: rtl/pm_pos_track.sv
`timescale 1ns/1ps
module pm_pos_track #(
  parameter int R     = 7,
  parameter int PIX_W = 8,
  parameter int IMG_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_sol,
  input  logic [PIX_W-1:0]           in_pix,
  output logic                       s1_valid,
  output logic                       s1_sol,
  output logic [PIX_W-1:0]           s1_pix,
  output logic [$clog2(IMG_W)-1:0]   s1_col,
  output logic [$clog2(2*R+1)-1:0]   s1_slot,
  output logic                       s1_first,
  output logic                       s1_fill,
  output logic                       s1_full
);
  localparam int N  = 2*R + 1;
  localparam int XW = $clog2(IMG_W);
  localparam int YW = $clog2(N + 1);
  localparam int SW = $clog2(N);

  logic          started_q;
  logic [XW-1:0] col_q;
  logic [YW-1:0] row_q;
  logic [SW-1:0] slot_q;

  // named events
  logic new_line, accept;
  assign new_line = in_valid && in_sol;
  assign accept   = in_valid && (in_sol || started_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      slot_q    <= '0;
      s1_valid  <= 1'b0;
      s1_sol    <= 1'b0;
      s1_pix    <= '0;
    end else begin
      s1_valid <= accept;
      s1_sol   <= new_line;
      if (accept) begin
        s1_pix <= in_pix;
        if (new_line) begin
          col_q     <= '0;
          started_q <= 1'b1;
          if (!started_q) begin
            row_q  <= '0;
            slot_q <= '0;
          end else begin
            if (row_q != YW'(N)) row_q <= row_q + 1'b1;
            slot_q <= (slot_q == SW'(N-1)) ? '0 : slot_q + 1'b1;
          end
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign s1_col   = col_q;
  assign s1_slot  = slot_q;
  assign s1_first = (row_q == '0);
  assign s1_fill  = (row_q < YW'(N));
  assign s1_full  = (row_q >= YW'(N-1));

  // R7: a line never runs past the last column
  assert_line_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_sol) |-> (col_q != XW'(IMG_W-1)));
endmodule

// File: rtl/pm_col_stage.sv
`timescale 1ns/1ps
module pm_col_stage import pm_pkg::*; #(
  parameter int R     = 7,
  parameter int PIX_W = 8,
  parameter int IMG_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s1_valid,
  input  logic                       s1_sol,
  input  logic [PIX_W-1:0]           s1_pix,
  input  logic [$clog2(IMG_W)-1:0]   s1_col,
  input  logic [$clog2(2*R+1)-1:0]   s1_slot,
  input  logic                       s1_first,
  input  logic                       s1_fill,
  input  logic                       s1_full,
  output logic                       s3_valid,
  output logic                       s3_sol,
  output logic                       s3_full,
  output logic [$clog2(IMG_W)-1:0]   s3_col,
  output acc_t                       s3_csum,
  output acc_t                       s3_cwt
);
  localparam int N       = 2*R + 1;
  localparam int XW      = $clog2(IMG_W);
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int CS_MAX  = PIX_MAX * N;
  localparam int CW_MAX  = PIX_MAX * R * (R + 1) / 2;

  logic [PIX_W-1:0] lb [N][IMG_W];
  acc_t cs_mem [IMG_W];
  acc_t cw_mem [IMG_W];

  logic          s2_valid, s2_sol, s2_full;
  logic [XW-1:0] s2_col;
  acc_t          s2_pix, s2_old_pix, s2_old_sum, s2_old_wt;

  // stage 2: fetch the departing pixel and the column's running sums
  always_ff @(posedge clk) begin
    if (s1_valid) lb[s1_slot][s1_col] <= s1_pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid   <= 1'b0;
      s2_sol     <= 1'b0;
      s2_full    <= 1'b0;
      s2_col     <= '0;
      s2_pix     <= '0;
      s2_old_pix <= '0;
      s2_old_sum <= '0;
      s2_old_wt  <= '0;
    end else begin
      s2_valid   <= s1_valid;
      s2_sol     <= s1_sol;
      s2_full    <= s1_full;
      s2_col     <= s1_col;
      s2_pix     <= acc_t'(s1_pix);
      s2_old_pix <= s1_fill  ? '0 : acc_t'(lb[s1_slot][s1_col]);
      s2_old_sum <= s1_first ? '0 : cs_mem[s1_col];
      s2_old_wt  <= s1_first ? '0 : cw_mem[s1_col];
    end
  end

  // stage 3: slide the column window down one row
  acc_t col_sum_new, col_wt_new;
  assign col_sum_new = s2_old_sum + s2_pix - s2_old_pix;
  assign col_wt_new  = wsum_step(s2_old_wt, s2_old_sum, s2_old_pix, s2_pix, R);

  always_ff @(posedge clk) begin
    if (s2_valid) begin
      cs_mem[s2_col] <= col_sum_new;
      cw_mem[s2_col] <= col_wt_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_valid <= 1'b0;
      s3_sol   <= 1'b0;
      s3_full  <= 1'b0;
      s3_col   <= '0;
      s3_csum  <= '0;
      s3_cwt   <= '0;
    end else begin
      s3_valid <= s2_valid;
      s3_sol   <= s2_sol;
      s3_full  <= s2_full;
      s3_col   <= s2_col;
      s3_csum  <= col_sum_new;
      s3_cwt   <= col_wt_new;
    end
  end

  // R1: column sum stays within what N pixels can hold
  assert_colsum_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (col_sum_new >= 0 && col_sum_new <= CS_MAX));
  // R2: row-weighted column sum bounded by one half-column at full scale
  assert_colwt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (col_wt_new >= -CW_MAX && col_wt_new <= CW_MAX));
endmodule

// File: rtl/pm_win_stage.sv
`timescale 1ns/1ps
module pm_win_stage import pm_pkg::*; #(
  parameter int R     = 7,
  parameter int IMG_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s3_valid,
  input  logic                       s3_sol,
  input  logic                       s3_full,
  input  logic [$clog2(IMG_W)-1:0]   s3_col,
  input  acc_t                       s3_csum,
  input  acc_t                       s3_cwt,
  output logic                       s4_valid,
  output acc_t                       s4_m10,
  output acc_t                       s4_m01
);
  localparam int N  = 2*R + 1;
  localparam int XW = $clog2(IMG_W);

  acc_t hs [N];
  acc_t hw [N];
  acc_t a_q;

  // line start: the along-line window restarts from empty
  acc_t leave_s, leave_w, a_prev, m10_prev, m01_prev;
  always_comb begin
    if (s3_sol) begin
      leave_s  = '0;
      leave_w  = '0;
      a_prev   = '0;
      m10_prev = '0;
      m01_prev = '0;
    end else begin
      leave_s  = hs[N-1];
      leave_w  = hw[N-1];
      a_prev   = a_q;
      m10_prev = s4_m10;
      m01_prev = s4_m01;
    end
  end

  logic win_done;
  assign win_done = s3_valid && s3_full && (s3_col >= XW'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        hs[i] <= '0;
        hw[i] <= '0;
      end
      a_q      <= '0;
      s4_m10   <= '0;
      s4_m01   <= '0;
      s4_valid <= 1'b0;
    end else begin
      s4_valid <= win_done;
      if (s3_valid) begin
        hs[0] <= s3_csum;
        hw[0] <= s3_cwt;
        for (int i = 1; i < N; i++) begin
          hs[i] <= s3_sol ? '0 : hs[i-1];
          hw[i] <= s3_sol ? '0 : hw[i-1];
        end
        a_q    <= a_prev + s3_csum - leave_s;
        s4_m10 <= wsum_step(m10_prev, a_prev, leave_s, s3_csum, R);
        s4_m01 <= m01_prev + s3_cwt - leave_w;
      end
    end
  end

  acc_t m10_abs, m01_abs;
  assign m10_abs = (s4_m10 < 0) ? -s4_m10 : s4_m10;
  assign m01_abs = (s4_m01 < 0) ? -s4_m01 : s4_m01;

  // R1/R2: no offset exceeds R, so each moment is bounded by R times the patch sum
  assert_m10_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m10_abs <= mul_k(a_q, R));
  assert_m01_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m01_abs <= mul_k(a_q, R));
  // R6: idle cycles leave the window untouched
  assert_bubble_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s3_valid |=> ($stable(a_q) && $stable(s4_m10) && $stable(s4_m01)));
endmodule

// File: rtl/pm_out_stage.sv
`timescale 1ns/1ps
module pm_out_stage import pm_pkg::*; #(
  parameter int R     = 7,
  parameter int PIX_W = 8,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s4_valid,
  input  acc_t             s4_m10,
  input  acc_t             s4_m01,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_m10_mag,
  output logic             out_m10_neg,
  output logic [OUT_W-1:0] out_m01_mag,
  output logic             out_m01_neg
);
  localparam int          N       = 2*R + 1;
  localparam int          MOM_MAX = ((1 << PIX_W) - 1) * N * R * (R + 1) / 2;
  localparam int          MAG_W   = $clog2(MOM_MAX + 1);
  localparam int unsigned SH      = (MAG_W > OUT_W) ? MAG_W - OUT_W : 0;

  acc_t m10_trunc, m01_trunc;
  assign m10_trunc = abs_shift(s4_m10, SH);
  assign m01_trunc = abs_shift(s4_m01, SH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_m10_mag <= '0;
      out_m10_neg <= 1'b0;
      out_m01_mag <= '0;
      out_m01_neg <= 1'b0;
    end else begin
      out_valid <= s4_valid;
      if (s4_valid) begin
        out_m10_mag <= OUT_W'(m10_trunc);
        out_m10_neg <= (s4_m10 < 0);
        out_m01_mag <= OUT_W'(m01_trunc);
        out_m01_neg <= (s4_m01 < 0);
      end
    end
  end

  // R4: after dropping the low bits nothing is lost at the top
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s4_valid |-> (m10_trunc < (1 << OUT_W) && m01_trunc < (1 << OUT_W)));
endmodule

// File: rtl/patch_moment_acc.sv
`timescale 1ns/1ps
module patch_moment_acc import pm_pkg::*; #(
  parameter int R     = 7,
  parameter int PIX_W = 8,
  parameter int IMG_W = 32,
  parameter int OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_m10_mag,
  output logic             out_m10_neg,
  output logic [OUT_W-1:0] out_m01_mag,
  output logic             out_m01_neg
);
  localparam int N  = 2*R + 1;
  localparam int XW = $clog2(IMG_W);
  localparam int SW = $clog2(N);

  logic             s1_valid, s1_sol, s1_first, s1_fill, s1_full;
  logic [PIX_W-1:0] s1_pix;
  logic [XW-1:0]    s1_col, s3_col;
  logic [SW-1:0]    s1_slot;
  logic             s3_valid, s3_sol, s3_full, s4_valid;
  acc_t             s3_csum, s3_cwt, s4_m10, s4_m01;

  pm_pos_track #(.R(R), .PIX_W(PIX_W), .IMG_W(IMG_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
    .s1_valid(s1_valid), .s1_sol(s1_sol), .s1_pix(s1_pix), .s1_col(s1_col),
    .s1_slot(s1_slot), .s1_first(s1_first), .s1_fill(s1_fill), .s1_full(s1_full));

  pm_col_stage #(.R(R), .PIX_W(PIX_W), .IMG_W(IMG_W)) u_col (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_sol(s1_sol), .s1_pix(s1_pix),
    .s1_col(s1_col), .s1_slot(s1_slot), .s1_first(s1_first), .s1_fill(s1_fill),
    .s1_full(s1_full), .s3_valid(s3_valid), .s3_sol(s3_sol), .s3_full(s3_full),
    .s3_col(s3_col), .s3_csum(s3_csum), .s3_cwt(s3_cwt));

  pm_win_stage #(.R(R), .IMG_W(IMG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .s3_valid(s3_valid), .s3_sol(s3_sol), .s3_full(s3_full),
    .s3_col(s3_col), .s3_csum(s3_csum), .s3_cwt(s3_cwt),
    .s4_valid(s4_valid), .s4_m10(s4_m10), .s4_m01(s4_m01));

  pm_out_stage #(.R(R), .PIX_W(PIX_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .s4_valid(s4_valid), .s4_m10(s4_m10), .s4_m01(s4_m01),
    .out_valid(out_valid), .out_m10_mag(out_m10_mag), .out_m10_neg(out_m10_neg),
    .out_m01_mag(out_m01_mag), .out_m01_neg(out_m01_neg));

  // R3/R5: every result traces back five edges to a mid-line input pixel
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && !in_sol, 5));
endmodule

// File: tb/test_patch_moment_acc.sv
`timescale 1ns/1ps
module test_patch_moment_acc;
  localparam int R     = 7;
  localparam int N     = 2*R + 1;
  localparam int IMG_W = 32;
  localparam int OUT_W = 12;
  localparam int H     = 20;
  localparam int PEAK  = 255 * N * R * (R + 1) / 2;
  localparam int SHB   = ($clog2(PEAK + 1) > OUT_W) ? $clog2(PEAK + 1) - OUT_W : 0;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_sol = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_valid, out_m10_neg, out_m01_neg;
  logic [OUT_W-1:0] out_m10_mag, out_m01_mag;

  patch_moment_acc #(.R(R), .PIX_W(8), .IMG_W(IMG_W), .OUT_W(OUT_W)) i_patch_moment_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
    .out_valid(out_valid), .out_m10_mag(out_m10_mag), .out_m10_neg(out_m10_neg),
    .out_m01_mag(out_m01_mag), .out_m01_neg(out_m01_neg));

  always #2.5 clk = ~clk;

  typedef struct { int due; int m10; int m01; int cx; int cy; } exp_t;
  exp_t  exp_q[$];
  int    img [H][IMG_W];
  int    n_chk = 0, n_bad = 0, edge_n = 0, n_seen = 0;
  string cur_req = "R8";

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic chk(input string req, input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic void ref_mom(input int cx, input int cy, output int m10, output int m01);
    m10 = 0; m01 = 0;
    for (int dy = -R; dy <= R; dy++)
      for (int dx = -R; dx <= R; dx++) begin
        m10 += dx * img[cy+dy][cx+dx];
        m01 += dy * img[cy+dy][cx+dx];
      end
  endfunction

  function automatic int mag_of(input int m);
    return ((m < 0) ? -m : m) >> SHB;
  endfunction

  // monitor: compares each result against the due edge and the brute-force sums
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        n_seen++;
        if (exp_q.size() == 0) chk("R5", "unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R3", "result edge", edge_n, e.due);
          chk(cur_req, $sformatf("m10 mag (%0d,%0d)", e.cx, e.cy), int'(out_m10_mag), mag_of(e.m10));
          chk(cur_req, $sformatf("m10 neg (%0d,%0d)", e.cx, e.cy), int'(out_m10_neg), int'(e.m10 < 0));
          chk(cur_req, $sformatf("m01 mag (%0d,%0d)", e.cx, e.cy), int'(out_m01_mag), mag_of(e.m01));
          chk(cur_req, $sformatf("m01 neg (%0d,%0d)", e.cx, e.cy), int'(out_m01_neg), int'(e.m01 < 0));
        end
      end else if (exp_q.size() > 0 && exp_q[0].due == edge_n) begin
        chk("R3", "missing valid", 0, 1);
        void'(exp_q.pop_front());
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (edge_n > 150000) begin
      n_bad++;
      $display("FAIL watchdog R3 cycles=%0d limit=%0d", edge_n, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_image(input string req, input int gap_pct);
    int m10, m01;
    cur_req = req;
    n_seen = 0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) begin
        while (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
          @(negedge clk);
          in_valid = 1'b0; in_sol = 1'b0; in_pix = 8'hFF;
        end
        @(negedge clk);
        in_valid = 1'b1; in_sol = (x == 0); in_pix = 8'(img[y][x]);
        if (x >= 2*R && y >= 2*R) begin
          exp_t e;
          ref_mom(x - R, y - R, m10, m01);
          e.due = edge_n + 5; e.m10 = m10; e.m01 = m01; e.cx = x - R; e.cy = y - R;
          exp_q.push_back(e);
        end
      end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0;
    repeat (10) @(negedge clk);
    chk(req, "results left pending", exp_q.size(), 0);
    chk("R5", "number of valid windows", n_seen, (IMG_W - 2*R) * (H - 2*R));
  endtask

  // R8: reset state, then stray pixels before the first line start are dropped
  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R8", "out_valid after reset", int'(out_valid), 0);
    chk("R8", "m10 mag after reset", int'(out_m10_mag), 0);
    chk("R8", "m01 mag after reset", int'(out_m01_mag), 0);
    chk("R8", "signs after reset", int'(out_m10_neg) + int'(out_m01_neg), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sol = 1'b0; in_pix = 8'hFF;
    end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = int'($urandom % 256);
    run_image("R8", 0);
  endtask

  // R1 R2: a flat image has zero moments, non-negative sign
  task automatic t_flat();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = 100;
    run_image("R1 R2 flat", 0);
  endtask

  // R1: horizontal ramp gives a positive horizontal moment only
  task automatic t_xramp();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = 7 * x;
    run_image("R1", 0);
  endtask

  // R2: vertical ramp, later lines brighter
  task automatic t_yramp();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = 12 * y;
    run_image("R2", 0);
  endtask

  // R4: left half at full scale reaches the extreme negative moment
  task automatic t_extreme();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = (x < 16) ? 255 : 0;
    run_image("R4", 0);
  endtask

  // R7: bright line tails must not reach the next line's first windows
  task automatic t_lines();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = (x >= 24) ? 255 : (y % 3) * 20;
    run_image("R7", 0);
  endtask

  // R1 R2: random content
  task automatic t_random();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = int'($urandom % 256);
    run_image("R1 R2 random", 0);
  endtask

  // R6: random content with idle cycles scattered through the stream
  task automatic t_bubbles();
    do_reset();
    for (int y = 0; y < H; y++)
      for (int x = 0; x < IMG_W; x++) img[y][x] = int'($urandom % 256);
    run_image("R6", 40);
  endtask

  initial begin
    t_reset();
    t_flat();
    t_xramp();
    t_yramp();
    t_extreme();
    t_lines();
    t_random();
    t_bubbles();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule